// File: doc/BRIEF.md
# Age-Ordered Redirect Filter

This block sits between the execute stage and the front of an out-of-order pipeline. It keeps one marker per hardware thread. The marker holds the sequence number of the youngest instruction that is still valid in the reorder buffer. Execute can raise several redirect requests in the same cycle. Each request carries a thread index, a sequence number, a target PC and a mispredict flag. The block passes on only a redirect that comes from an instruction older than the marker, because only such an instruction can still be in flight.

For each thread, the oldest candidate request is chosen combinationally and then compared with the marker. An accepted redirect does two things. It pulls the marker back to the squashing instruction's sequence number. It also produces a registered squash broadcast for that thread, which tells every earlier stage the sequence number to squash down to, together with the target PC and the mispredict flag. Allocation notices from rename move the marker forward. Sequence numbers are unsigned and are assumed not to wrap.

Top module: `redirect_filter`

## Requirements
- R1: While rst_ni is low, every thread's marker is zero and every sq_valid_o bit is low, with sq_seq_o, sq_pc_o and sq_mispred_o all zero.
- R2: A redirect request for thread t (redir_tid_i selects thread t by its binary value) is accepted only if its sequence number is strictly smaller than the marker of thread t. A request with a sequence number equal to or larger than the marker produces no broadcast.
- R3: When a redirect is accepted, the marker of that thread becomes the accepted sequence number. After that, a request with the same sequence number is dropped and a strictly smaller one is accepted.
- R4: When several valid requests target one thread in the same cycle, the one with the smallest sequence number is the only candidate. On equal sequence numbers, the lowest request index wins.
- R5: The broadcast for an accepted redirect carries the winner's sequence number on sq_seq_o, its target PC on sq_pc_o and its mispredict flag on sq_mispred_o.
- R6: When alloc_valid_i[t] is high and no redirect is accepted for thread t in that cycle, the marker of thread t is set to alloc_seq_i[t].
- R7: In a cycle in which a redirect is accepted for thread t, alloc_valid_i[t] has no effect on the marker of thread t.
- R8: The broadcast is registered. sq_valid_o[t] is high in exactly the cycle after each cycle in which a redirect for thread t is accepted, and is low otherwise.
- R9: Threads are independent. Requests and allocations for one thread never change another thread's marker or broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| redir_valid_i | input | NUM_REQ | Valid bit for each redirect request |
| redir_tid_i | input | NUM_REQ*TID_W | Thread index of each request |
| redir_seq_i | input | NUM_REQ*SEQ_W | Sequence number of the squashing instruction |
| redir_pc_i | input | NUM_REQ*PC_W | Redirect target PC |
| redir_mispred_i | input | NUM_REQ | Branch mispredict flag |
| alloc_valid_i | input | NUM_THREADS | Rename allocated a new youngest instruction |
| alloc_seq_i | input | NUM_THREADS*SEQ_W | Sequence number of that allocation |
| sq_valid_o | output | NUM_THREADS | Squash broadcast valid, one per thread |
| sq_seq_o | output | NUM_THREADS*SEQ_W | Sequence number to squash down to |
| sq_pc_o | output | NUM_THREADS*PC_W | Redirect target PC |
| sq_mispred_o | output | NUM_THREADS | Mispredict flag of the accepted redirect |

## Verification
The hardest case to reach from the ports is this: in one cycle, two or three requests target the same thread, their sequence numbers tie or sit just around the marker, and an allocation for that thread arrives at the same time. Only then can the tie-break, the strict comparison and the suppression of the allocation be told apart. The random stimulus keeps every sequence number within a few counts of the bench's own model of each marker, and it uses only two threads, so collisions of this kind are frequent. Directed cycles then force an exact tie, a request equal to the marker and an allocation in the same cycle as an accept.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned SEQ_W_DEF = 16;
  localparam int unsigned PC_W_DEF  = 32;

  // unsigned, non-wrapping age compare
  function automatic logic seq_older(input logic [63:0] a, input logic [63:0] b);
    return a < b;
  endfunction
endpackage

// File: rtl/rf_oldest_pick.sv
module rf_oldest_pick #(
  parameter int unsigned NUM_REQ = 3,
  parameter int unsigned SEQ_W   = rf_pkg::SEQ_W_DEF,
  parameter int unsigned PC_W    = rf_pkg::PC_W_DEF
) (
  input  logic [NUM_REQ-1:0]            cand_i,
  input  logic [NUM_REQ-1:0][SEQ_W-1:0] seq_i,
  input  logic [NUM_REQ-1:0][PC_W-1:0]  pc_i,
  input  logic [NUM_REQ-1:0]            mis_i,
  output logic                          found_o,
  output logic [SEQ_W-1:0]              seq_o,
  output logic [PC_W-1:0]               pc_o,
  output logic                          mis_o
);
  always_comb begin
    found_o = 1'b0;
    seq_o   = '0;
    pc_o    = '0;
    mis_o   = 1'b0;
    // strict compare keeps the lowest index on ties
    for (int i = 0; i < NUM_REQ; i++) begin
      if (cand_i[i] && (!found_o || rf_pkg::seq_older(64'(seq_i[i]), 64'(seq_o)))) begin
        found_o = 1'b1;
        seq_o   = seq_i[i];
        pc_o    = pc_i[i];
        mis_o   = mis_i[i];
      end
    end
  end

  // R4
  always_comb begin
    for (int i = 0; i < NUM_REQ; i++) begin
      if (cand_i[i]) begin
        oldest_sel_chk: assert (found_o && seq_o <= seq_i[i]);
      end
    end
  end
endmodule

// File: rtl/rf_thread_ctl.sv
module rf_thread_ctl #(
  parameter int unsigned SEQ_W = rf_pkg::SEQ_W_DEF,
  parameter int unsigned PC_W  = rf_pkg::PC_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             found_i,
  input  logic [SEQ_W-1:0] sel_seq_i,
  input  logic [PC_W-1:0]  sel_pc_i,
  input  logic             sel_mis_i,
  input  logic             alloc_v_i,
  input  logic [SEQ_W-1:0] alloc_seq_i,
  output logic             sq_v_o,
  output logic [SEQ_W-1:0] sq_seq_o,
  output logic [PC_W-1:0]  sq_pc_o,
  output logic             sq_mis_o
);
  logic [SEQ_W-1:0] marker_q;
  logic             accept;

  assign accept = found_i && rf_pkg::seq_older(64'(sel_seq_i), 64'(marker_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      marker_q <= '0;
      sq_v_o   <= 1'b0;
      sq_seq_o <= '0;
      sq_pc_o  <= '0;
      sq_mis_o <= 1'b0;
    end else begin
      sq_v_o <= accept;
      if (accept) begin
        marker_q <= sel_seq_i;
        sq_seq_o <= sel_seq_i;
        sq_pc_o  <= sel_pc_i;
        sq_mis_o <= sel_mis_i;
      end else if (alloc_v_i) begin
        marker_q <= alloc_seq_i;
      end
    end
  end

  // R2
  older_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sq_v_o |-> $past(sel_seq_i) < $past(marker_q));
  // R3
  marker_pullback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sq_v_o |-> marker_q == sq_seq_o && marker_q < $past(marker_q));
  // R8
  no_spurious_sq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !found_i |=> !sq_v_o);
  // R6
  alloc_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_v_i && !found_i) |=> marker_q == $past(alloc_seq_i));
  // R7
  alloc_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_v_i && accept) |=> marker_q == $past(sel_seq_i));
endmodule

// File: rtl/redirect_filter.sv
module redirect_filter #(
  parameter int unsigned NUM_THREADS = 2,
  parameter int unsigned NUM_REQ     = 3,
  parameter int unsigned SEQ_W       = rf_pkg::SEQ_W_DEF,
  parameter int unsigned PC_W        = rf_pkg::PC_W_DEF,
  localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_REQ-1:0]                redir_valid_i,
  input  logic [NUM_REQ-1:0][TID_W-1:0]     redir_tid_i,
  input  logic [NUM_REQ-1:0][SEQ_W-1:0]     redir_seq_i,
  input  logic [NUM_REQ-1:0][PC_W-1:0]      redir_pc_i,
  input  logic [NUM_REQ-1:0]                redir_mispred_i,
  input  logic [NUM_THREADS-1:0]            alloc_valid_i,
  input  logic [NUM_THREADS-1:0][SEQ_W-1:0] alloc_seq_i,
  output logic [NUM_THREADS-1:0]            sq_valid_o,
  output logic [NUM_THREADS-1:0][SEQ_W-1:0] sq_seq_o,
  output logic [NUM_THREADS-1:0][PC_W-1:0]  sq_pc_o,
  output logic [NUM_THREADS-1:0]            sq_mispred_o
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [NUM_REQ-1:0] cand;
    logic               found;
    logic [SEQ_W-1:0]   sel_seq;
    logic [PC_W-1:0]    sel_pc;
    logic               sel_mis;

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
      assign cand[i] = redir_valid_i[i] && (redir_tid_i[i] == TID_W'(t));
    end

    rf_oldest_pick #(.NUM_REQ(NUM_REQ), .SEQ_W(SEQ_W), .PC_W(PC_W)) u_pick (
      .cand_i (cand),
      .seq_i  (redir_seq_i),
      .pc_i   (redir_pc_i),
      .mis_i  (redir_mispred_i),
      .found_o(found),
      .seq_o  (sel_seq),
      .pc_o   (sel_pc),
      .mis_o  (sel_mis)
    );

    rf_thread_ctl #(.SEQ_W(SEQ_W), .PC_W(PC_W)) u_ctl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .found_i    (found),
      .sel_seq_i  (sel_seq),
      .sel_pc_i   (sel_pc),
      .sel_mis_i  (sel_mis),
      .alloc_v_i  (alloc_valid_i[t]),
      .alloc_seq_i(alloc_seq_i[t]),
      .sq_v_o     (sq_valid_o[t]),
      .sq_seq_o   (sq_seq_o[t]),
      .sq_pc_o    (sq_pc_o[t]),
      .sq_mis_o   (sq_mispred_o[t])
    );
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> sq_valid_o == '0);
endmodule

// File: tb/redirect_filter_bench.sv
module redirect_filter_bench;
  localparam int NT = 2, NR = 3, SW = 16, PW = 32, TW = 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NR-1:0]         rv = '0;
  logic [NR-1:0][TW-1:0] rt = '0;
  logic [NR-1:0][SW-1:0] rs = '0;
  logic [NR-1:0][PW-1:0] rp = '0;
  logic [NR-1:0]         rm = '0;
  logic [NT-1:0]         av = '0;
  logic [NT-1:0][SW-1:0] as_ = '0;
  logic [NT-1:0]         sv;
  logic [NT-1:0][SW-1:0] ss;
  logic [NT-1:0][PW-1:0] sp;
  logic [NT-1:0]         sm;

  int checks = 0, fails = 0, cyc = 0;
  int mk [NT];
  bit ev [NT]; int es [NT]; logic [PW-1:0] ep [NT]; bit em [NT];

  always #10 clk = ~clk;

  redirect_filter #(.NUM_THREADS(NT), .NUM_REQ(NR), .SEQ_W(SW), .PC_W(PW)) u_redirect_filter (
    .clk_i(clk), .rst_ni(rst_ni), .redir_valid_i(rv), .redir_tid_i(rt), .redir_seq_i(rs),
    .redir_pc_i(rp), .redir_mispred_i(rm), .alloc_valid_i(av), .alloc_seq_i(as_),
    .sq_valid_o(sv), .sq_seq_o(ss), .sq_pc_o(sp), .sq_mispred_o(sm));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  // model: R2 R3 R4 R6 R7 R9
  task automatic predict();
    for (int t = 0; t < NT; t++) begin
      bit f = 0; int bs = 0; logic [PW-1:0] bp = '0; bit bm = 0;
      for (int i = 0; i < NR; i++)
        if (rv[i] && int'(rt[i]) == t && (!f || int'(rs[i]) < bs)) begin
          f = 1; bs = int'(rs[i]); bp = rp[i]; bm = rm[i];
        end
      ev[t] = f && bs < mk[t];
      if (ev[t]) begin es[t] = bs; ep[t] = bp; em[t] = bm; mk[t] = bs; end
      else if (av[t]) mk[t] = int'(as_[t]);
    end
  endtask

  task automatic step(input string tag);
    predict();
    @(posedge clk); @(negedge clk); cyc++;
    for (int t = 0; t < NT; t++) begin
      chk(sv[t] == ev[t], {tag, " R8 valid"}, sv[t], ev[t]);
      if (ev[t] && sv[t]) begin
        chk(int'(ss[t]) == es[t], {tag, " R5 seq"}, ss[t], es[t]);
        chk(sp[t] == ep[t], {tag, " R5 pc"}, sp[t], ep[t]);
        chk(sm[t] == em[t], {tag, " R5 mispred"}, sm[t], em[t]);
      end
    end
  endtask

  task automatic idle();
    rv = '0; av = '0;
  endtask

  initial begin
    for (int t = 0; t < NT; t++) mk[t] = 0;
    @(negedge clk); @(negedge clk);
    // R1
    chk(sv == '0, "R1 valid", sv, 0);
    chk(ss == '0 && sp == '0 && sm == '0, "R1 data", ss, 0);
    rst_ni = 1'b1;
    // R1 marker zero: any redirect dropped
    rv = 3'b001; rt[0] = 0; rs[0] = 0; step("R1/R2 zero marker");
    // R6 alloc thread 0 to 100, thread 1 to 50
    idle(); av = 2'b11; as_[0] = 100; as_[1] = 50; step("R6 alloc");
    // R2 equal dropped
    idle(); rv = 3'b001; rt[0] = 0; rs[0] = 100; step("R2 equal");
    // R4 tie, lowest index; R7 alloc in same cycle ignored; R9 thread1 untouched
    idle(); rv = 3'b111; rt = '{0, 0, 0}; rs = '{90, 80, 80}; rp = '{32'h30, 32'h20, 32'h10};
    rm = 3'b010; av = 2'b01; as_[0] = 500; step("R4/R7 tie+alloc");
    // R3 same seq now dropped, smaller accepted
    idle(); rv = 3'b001; rt[0] = 0; rs[0] = 80; step("R3 equal after pull");
    idle(); rv = 3'b001; rt[0] = 0; rs[0] = 79; rp[0] = 32'hABC; rm[0] = 1; step("R3 smaller");
    // R9 thread 1 still at 50
    idle(); rv = 3'b011; rt[0] = 1; rs[0] = 49; rt[1] = 0; rs[1] = 200; step("R9 independent");
    idle(); step("R8 drop after one");
    // random
    for (int n = 0; n < 4000; n++) begin
      idle();
      for (int i = 0; i < NR; i++) begin
        int t = int'($urandom_range(0, NT - 1));
        int s = mk[t] + int'($urandom_range(0, 6)) - 3;
        rv[i] = ($urandom_range(0, 9) < 4);
        rt[i] = TW'(t);
        rs[i] = SW'(s < 0 ? 0 : s);
        rp[i] = $urandom; rm[i] = $urandom_range(0, 1);
      end
      for (int t = 0; t < NT; t++) begin
        av[t] = ($urandom_range(0, 9) < 4);
        as_[t] = SW'(mk[t] + int'($urandom_range(1, 8)));
      end
      step("rand R2/R4/R6/R7/R9");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule